// File: doc/BRIEF.md
# Interrupt-Driven Single-Move Transfer Server

The transfer server answers one serviced interrupt by running one memory-to-memory move described by a small control record held in ordinary memory. An external arbiter picks the channel and hands over the record's base address with a one-cycle start pulse. The server reads the six-byte record through a byte-wide request/ready memory port. It decodes the control byte and copies one byte or one little-endian 16-bit word from the record's source pointer to its destination pointer. It then writes the decremented count and the new pointers back into the record, and pulses done. The pulse carries a flag that says whether the count has just reached zero, so the surrounding logic can raise an end-of-service interrupt.

Each pointer is either kept as advanced or restored after every move. The restore value comes from a per-channel pair of shadow registers, loaded by an arm strobe before the channel is first used. Modes other than single-move are not executed. They abort the service with an error flag and touch no memory. A service also aborts with its own flag when a keep/advance setting is not consistent, or when a word move points at an odd address.

Top module: `xfer_server`

## Requirements
- R1: The record is read as count at offset 0, control byte at offset 1, source pointer at offsets 2 (low) and 3 (high), and destination pointer at offsets 4 (low) and 5 (high). With control bit 4 = 1 exactly one byte is copied from the source to the destination, and the byte after the destination stays untouched.
- R2: With control bit 4 = 0 the bytes at source and source+1 are copied to destination and destination+1.
- R3: Every successful service writes count-1 back to offset 0. done_o is accompanied by last_o = 1 exactly when that written count is zero.
- R4: Control bit 1 (source) and bit 0 (destination) advance the pointer written back by 2 for a word and 1 for a byte, independently of each other.
- R5: When control bit 3 (source) or bit 2 (destination) is 0, the pointer written back is the channel's armed shadow value instead of the current one.
- R6: A mode field (control bits 7:5) other than 3'b101 ends the service with err_mode_o. No memory is written, and the record and destination stay unchanged.
- R7: If bit 3 differs from bit 1, or bit 2 differs from bit 0, the service ends with err_cfg_o and writes nothing. Mode errors take priority over this check.
- R8: A word move with an odd source or destination pointer ends with err_align_o and writes nothing.
- R9: done_o is high for exactly one clock per service and busy_o falls after it. Error flags and last_o appear only together with done_o, and at most one error flag is set.
- R10: start_i pulses arriving while busy_o is high are ignored.
- R11: Shadow pointers are kept per channel. Arming one channel leaves the others unchanged.
- R12: After reset, busy_o, done_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Load shadow pointers of arm_ch_i |
| arm_ch_i | input | CH_W | Channel to arm |
| arm_src_i | input | ADDR_W | Source shadow value |
| arm_dst_i | input | ADDR_W | Destination shadow value |
| start_i | input | 1 | Begin a service (ignored when busy) |
| start_ch_i | input | CH_W | Channel being serviced |
| cb_base_i | input | ADDR_W | Base address of the record |
| busy_o | output | 1 | Service in progress |
| done_o | output | 1 | One-cycle completion pulse |
| last_o | output | 1 | Count reached zero (with done_o) |
| err_mode_o | output | 1 | Unsupported mode (with done_o) |
| err_cfg_o | output | 1 | Inconsistent keep/advance pair (with done_o) |
| err_align_o | output | 1 | Odd pointer on word move (with done_o) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Access completes this cycle |

## Verification
Restore-on-move is the hardest case to reach from the ports. With consistent pairs, a restored pointer never moves, so the effect only shows if the armed shadow differs from the pointer in the record. The stimulus therefore arms a shadow on purpose with a value different from the record's pointer. It then checks that the shadow value, not the record's pointer, is written back, and repeats this on a second channel to show the shadows are separate. A start pulse issued in the middle of a service, while the memory model stalls ready on a fixed pattern, covers the ignore-while-busy path.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CHECK,
      ST_READ,
      ST_WRITE,
      ST_WBACK,
      ST_FIN
   } state_t;

   typedef enum logic [1:0] {
      ERR_NONE,
      ERR_MODE,
      ERR_CFG,
      ERR_ALIGN
   } err_t;

   // control byte, packed so that bit positions match the record
   typedef struct packed {
      logic [2:0] mode;
      logic       byte_sz;
      logic       keep_src;
      logic       keep_dst;
      logic       inc_src;
      logic       inc_dst;
   } ctl_t;

   localparam logic [2:0] MODE_SINGLE = 3'b101;

endpackage

// File: rtl/xfer_ctl_decode.sv
module xfer_ctl_decode
   import xfer_pkg::*;
(
   input  logic [7:0] ctl_i,
   input  logic       src_lsb_i,
   input  logic       dst_lsb_i,
   output err_t       err_o,
   output logic       word_o
);

   ctl_t ctl;
   assign ctl    = ctl_t'(ctl_i);
   assign word_o = ~ctl.byte_sz;

   always_comb begin
      if (ctl.mode != MODE_SINGLE) begin
         err_o = ERR_MODE;
      end else if ((ctl.keep_src != ctl.inc_src) || (ctl.keep_dst != ctl.inc_dst)) begin
         err_o = ERR_CFG;
      end else if (word_o && (src_lsb_i || dst_lsb_i)) begin
         err_o = ERR_ALIGN;
      end else begin
         err_o = ERR_NONE;
      end
   end

endmodule

// File: rtl/xfer_addr_step.sv
module xfer_addr_step #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] shadow_i,
   input  logic              inc_i,
   input  logic              keep_i,
   input  logic              word_i,
   output logic [ADDR_W-1:0] wb_o
);

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] advanced;

   assign step     = inc_i ? (word_i ? ADDR_W'(2) : ADDR_W'(1)) : '0;
   assign advanced = cur_i + step;
   assign wb_o     = keep_i ? advanced : shadow_i;

endmodule

// File: rtl/xfer_shadow_bank.sv
module xfer_shadow_bank #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic [CH_W-1:0]   arm_ch_i,
   input  logic [ADDR_W-1:0] arm_src_i,
   input  logic [ADDR_W-1:0] arm_dst_i,
   input  logic [CH_W-1:0]   rd_ch_i,
   output logic [ADDR_W-1:0] src_o,
   output logic [ADDR_W-1:0] dst_o
);

   logic [ADDR_W-1:0] src_sh [NUM_CH];
   logic [ADDR_W-1:0] dst_sh [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_sh[c] <= '0;
            dst_sh[c] <= '0;
         end else if (arm_i && (arm_ch_i == CH_W'(c))) begin
            src_sh[c] <= arm_src_i;
            dst_sh[c] <= arm_dst_i;
         end
      end
   end

   always_comb begin
      src_o = '0;
      dst_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_ch_i == CH_W'(c)) begin
            src_o = src_sh[c];
            dst_o = dst_sh[c];
         end
      end
   end

endmodule

// File: rtl/xfer_server.sv
module xfer_server
   import xfer_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic [CH_W-1:0]   arm_ch_i,
   input  logic [ADDR_W-1:0] arm_src_i,
   input  logic [ADDR_W-1:0] arm_dst_i,
   input  logic              start_i,
   input  logic [CH_W-1:0]   start_ch_i,
   input  logic [ADDR_W-1:0] cb_base_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              last_o,
   output logic              err_mode_o,
   output logic              err_cfg_o,
   output logic              err_align_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   input  logic [7:0]        mem_rdata_i,
   input  logic              mem_rdy_i
);

   localparam int CB_BYTES = 6;
   localparam int WB_BYTES = 5;
   localparam int IDX_W    = $clog2(CB_BYTES);

   initial begin
      if (ADDR_W != 16) $fatal(1, "record stores two-byte pointers: ADDR_W must be 16");
      if (CNT_W != 8)   $fatal(1, "record count field is one byte: CNT_W must be 8");
      if (NUM_CH < 1)   $fatal(1, "NUM_CH must be at least 1");
   end

   state_t             state;
   logic [IDX_W-1:0]   idx;
   logic [ADDR_W-1:0]  base_q;
   logic [CH_W-1:0]    ch_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [7:0]         ctl_q;
   logic [ADDR_W-1:0]  src_q;
   logic [ADDR_W-1:0]  dst_q;
   logic [15:0]        data_q;
   err_t               err_q;
   logic               last_q;
   logic [CNT_W-1:0]   cnt_new_q;
   logic [ADDR_W-1:0]  src_wb_q;
   logic [ADDR_W-1:0]  dst_wb_q;

   ctl_t               ctl_s;
   err_t               dec_err;
   logic               word;
   logic [ADDR_W-1:0]  sh_src;
   logic [ADDR_W-1:0]  sh_dst;
   logic [ADDR_W-1:0]  src_step;
   logic [ADDR_W-1:0]  dst_step;
   logic [IDX_W-1:0]   last_rw;
   logic [IDX_W-1:0]   wb_ofs;
   logic [7:0]         wb_byte;

   assign ctl_s   = ctl_t'(ctl_q);
   assign last_rw = word ? IDX_W'(1) : IDX_W'(0);

   xfer_ctl_decode u_dec (
      .ctl_i     (ctl_q),
      .src_lsb_i (src_q[0]),
      .dst_lsb_i (dst_q[0]),
      .err_o     (dec_err),
      .word_o    (word)
   );

   xfer_shadow_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm_i),
      .arm_ch_i  (arm_ch_i),
      .arm_src_i (arm_src_i),
      .arm_dst_i (arm_dst_i),
      .rd_ch_i   (ch_q),
      .src_o     (sh_src),
      .dst_o     (sh_dst)
   );

   xfer_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
      .cur_i    (src_q),
      .shadow_i (sh_src),
      .inc_i    (ctl_s.inc_src),
      .keep_i   (ctl_s.keep_src),
      .word_i   (word),
      .wb_o     (src_step)
   );

   xfer_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
      .cur_i    (dst_q),
      .shadow_i (sh_dst),
      .inc_i    (ctl_s.inc_dst),
      .keep_i   (ctl_s.keep_dst),
      .word_i   (word),
      .wb_o     (dst_step)
   );

   // write-back order: count, source low/high, destination low/high
   always_comb begin
      wb_ofs = (idx == '0) ? IDX_W'(0) : idx + IDX_W'(1);
      unique case (idx)
         IDX_W'(0): wb_byte = cnt_new_q;
         IDX_W'(1): wb_byte = src_wb_q[7:0];
         IDX_W'(2): wb_byte = src_wb_q[15:8];
         IDX_W'(3): wb_byte = dst_wb_q[7:0];
         default:   wb_byte = dst_wb_q[15:8];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         base_q    <= '0;
         ch_q      <= '0;
         cnt_q     <= '0;
         ctl_q     <= '0;
         src_q     <= '0;
         dst_q     <= '0;
         data_q    <= '0;
         err_q     <= ERR_NONE;
         last_q    <= 1'b0;
         cnt_new_q <= '0;
         src_wb_q  <= '0;
         dst_wb_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  base_q <= cb_base_i;
                  ch_q   <= start_ch_i;
                  idx    <= '0;
                  err_q  <= ERR_NONE;
                  last_q <= 1'b0;
                  state  <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_rdy_i) begin
                  unique case (idx)
                     IDX_W'(0): cnt_q         <= mem_rdata_i;
                     IDX_W'(1): ctl_q         <= mem_rdata_i;
                     IDX_W'(2): src_q[7:0]    <= mem_rdata_i;
                     IDX_W'(3): src_q[15:8]   <= mem_rdata_i;
                     IDX_W'(4): dst_q[7:0]    <= mem_rdata_i;
                     default:   dst_q[15:8]   <= mem_rdata_i;
                  endcase
                  if (idx == IDX_W'(CB_BYTES - 1)) begin
                     idx   <= '0;
                     state <= ST_CHECK;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            ST_CHECK: begin
               err_q     <= dec_err;
               cnt_new_q <= cnt_q - CNT_W'(1);
               src_wb_q  <= src_step;
               dst_wb_q  <= dst_step;
               last_q    <= (dec_err == ERR_NONE) && (cnt_q == CNT_W'(1));
               idx       <= '0;
               state     <= (dec_err == ERR_NONE) ? ST_READ : ST_FIN;
            end
            ST_READ: begin
               if (mem_rdy_i) begin
                  if (idx[0]) data_q[15:8] <= mem_rdata_i;
                  else        data_q[7:0]  <= mem_rdata_i;
                  if (idx == last_rw) begin
                     idx   <= '0;
                     state <= ST_WRITE;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            ST_WRITE: begin
               if (mem_rdy_i) begin
                  if (idx == last_rw) begin
                     idx   <= '0;
                     state <= ST_WBACK;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            ST_WBACK: begin
               if (mem_rdy_i) begin
                  if (idx == IDX_W'(WB_BYTES - 1)) begin
                     idx   <= '0;
                     state <= ST_FIN;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state)
         ST_FETCH: begin
            mem_req_o  = 1'b1;
            mem_addr_o = base_q + ADDR_W'(idx);
         end
         ST_READ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = src_q + ADDR_W'(idx);
         end
         ST_WRITE: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = dst_q + ADDR_W'(idx);
            mem_wdata_o = idx[0] ? data_q[15:8] : data_q[7:0];
         end
         ST_WBACK: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = base_q + ADDR_W'(wb_ofs);
            mem_wdata_o = wb_byte;
         end
         default: ;
      endcase
   end

   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_FIN);
   assign last_o      = done_o && last_q;
   assign err_mode_o  = done_o && (err_q == ERR_MODE);
   assign err_cfg_o   = done_o && (err_q == ERR_CFG);
   assign err_align_o = done_o && (err_q == ERR_ALIGN);

endmodule

// File: rtl/xfer_server_chk.sv
module xfer_server_chk (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic done_o,
   input logic last_o,
   input logic err_mode_o,
   input logic err_cfg_o,
   input logic err_align_o,
   input logic mem_req_o,
   input logic mem_we_o,
   input logic mem_rdy_i
);

   logic wrote;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               wrote <= 1'b0;
      else if (!busy_o)                         wrote <= 1'b0;
      else if (mem_req_o && mem_we_o && mem_rdy_i) wrote <= 1'b1;
   end

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_mode_o, err_cfg_o, err_align_o}));
   assert_flag_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_mode_o || err_cfg_o || err_align_o || last_o) |-> done_o);
   assert_last_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> !(err_mode_o || err_cfg_o || err_align_o));
   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o);
   assert_no_write_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_mode_o |-> !wrote);
   assert_no_write_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_cfg_o |-> !wrote);
   assert_no_write_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_align_o |-> !wrote);
   assert_we_with_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> mem_req_o);

endmodule

bind xfer_server xfer_server_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .last_o      (last_o),
   .err_mode_o  (err_mode_o),
   .err_cfg_o   (err_cfg_o),
   .err_align_o (err_align_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_rdy_i   (mem_rdy_i)
);

// File: tb/xfer_server_bench.sv
`timescale 1ns/1ps
module xfer_server_bench;

   localparam int NUM_CH = 4;
   localparam int CH_W   = 2;
   localparam int NVEC   = 10;

   typedef struct packed {
      logic [7:0]  ctl;
      logic [7:0]  cnt;
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] asrc;
      logic [15:0] adst;
      logic [7:0]  ecnt;
      logic [15:0] esrc;
      logic [15:0] edst;
      logic        elast;
      logic [1:0]  eerr;   // 0 none, 1 mode, 2 pair, 3 alignment
   } vec_t;

   localparam logic [122:0] VEC [NVEC] = '{
      {8'hB0, 8'd3, 16'h0200, 16'h0400, 16'h0200, 16'h0400, 8'd2, 16'h0200, 16'h0400, 1'b0, 2'd0},
      {8'hA5, 8'd9, 16'h0220, 16'h0600, 16'h0220, 16'h0600, 8'd8, 16'h0220, 16'h0602, 1'b0, 2'd0},
      {8'hBF, 8'd1, 16'h0231, 16'h0411, 16'h0231, 16'h0411, 8'd0, 16'h0232, 16'h0412, 1'b1, 2'd0},
      {8'hAF, 8'd5, 16'h0240, 16'h0620, 16'h0240, 16'h0620, 8'd4, 16'h0242, 16'h0622, 1'b0, 2'd0},
      {8'hB0, 8'd4, 16'h0250, 16'h0430, 16'h0260, 16'h0440, 8'd3, 16'h0260, 16'h0440, 1'b0, 2'd0},
      {8'h10, 8'd7, 16'h02A0, 16'h0470, 16'h02A0, 16'h0470, 8'd7, 16'h02A0, 16'h0470, 1'b0, 2'd1},
      {8'hF0, 8'd7, 16'h02B0, 16'h0480, 16'h02B0, 16'h0480, 8'd7, 16'h02B0, 16'h0480, 1'b0, 2'd1},
      {8'hB8, 8'd7, 16'h0290, 16'h0460, 16'h0290, 16'h0460, 8'd7, 16'h0290, 16'h0460, 1'b0, 2'd2},
      {8'hA0, 8'd6, 16'h0270, 16'h0451, 16'h0270, 16'h0451, 8'd6, 16'h0270, 16'h0451, 1'b0, 2'd3},
      {8'hA5, 8'd6, 16'h0281, 16'h0490, 16'h0281, 16'h0490, 8'd6, 16'h0281, 16'h0490, 1'b0, 2'd3}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              arm = 1'b0;
   logic [CH_W-1:0]   arm_ch = '0;
   logic [15:0]       arm_src = '0;
   logic [15:0]       arm_dst = '0;
   logic              start = 1'b0;
   logic [CH_W-1:0]   start_ch = '0;
   logic [15:0]       cb_base = '0;
   logic              busy, done, last, e_mode, e_cfg, e_align;
   logic              mem_req, mem_we, mem_rdy;
   logic [15:0]       mem_addr;
   logic [7:0]        mem_wdata, mem_rdata;

   logic [7:0]  mem [4096];
   logic        tb_we = 1'b0;
   logic [11:0] tb_addr = '0;
   logic [7:0]  tb_wdata = '0;
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   xfer_server #(.NUM_CH(NUM_CH)) u_xfer_server (
      .clk(clk), .rst_n(rst_n),
      .arm_i(arm), .arm_ch_i(arm_ch), .arm_src_i(arm_src), .arm_dst_i(arm_dst),
      .start_i(start), .start_ch_i(start_ch), .cb_base_i(cb_base),
      .busy_o(busy), .done_o(done), .last_o(last),
      .err_mode_o(e_mode), .err_cfg_o(e_cfg), .err_align_o(e_align),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy)
   );

   assign mem_rdy   = (cyc % 3) != 2;
   assign mem_rdata = mem[mem_addr[11:0]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && mem_we && mem_rdy) mem[mem_addr[11:0]] <= mem_wdata;
      if (tb_we) mem[tb_addr] <= tb_wdata;
   end

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ 8'h3C;
   endfunction

   function automatic logic [15:0] rd16(input logic [15:0] a);
      return {mem[a[11:0] + 12'd1], mem[a[11:0]]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = a[11:0]; tb_wdata = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic arm_ch_task(input int ch, input logic [15:0] s, input logic [15:0] d);
      @(negedge clk);
      arm = 1'b1; arm_ch = CH_W'(ch); arm_src = s; arm_dst = d;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic load_cb(input logic [15:0] base, input logic [7:0] ctl, input logic [7:0] cnt,
                          input logic [15:0] s, input logic [15:0] d);
      put(base, cnt);
      put(base + 16'd1, ctl);
      put(base + 16'd2, s[7:0]);
      put(base + 16'd3, s[15:8]);
      put(base + 16'd4, d[7:0]);
      put(base + 16'd5, d[15:8]);
      put(s, pat(s));
      put(s + 16'd1, pat(s + 16'd1));
      put(d, 8'hEE);
      put(d + 16'd1, 8'hEE);
   endtask

   task automatic kick(input int ch, input logic [15:0] base);
      @(negedge clk);
      start = 1'b1; start_ch = CH_W'(ch); cb_base = base;
      @(negedge clk);
      start = 1'b0;
   endtask

   // waits for done; returns flags sampled in that cycle and done one cycle later
   task automatic wait_done(output logic [1:0] err, output logic lst, output logic seen,
                            output logic done_after);
      seen = 1'b0; err = 2'd0; lst = 1'b0; done_after = 1'b0;
      for (int n = 0; n < 2000 && !seen; n++) begin
         if (done) begin
            seen = 1'b1;
            lst  = last;
            err  = e_mode ? 2'd1 : e_cfg ? 2'd2 : e_align ? 2'd3 : 2'd0;
         end else begin
            @(negedge clk);
         end
      end
      @(negedge clk);
      done_after = done;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0]  err;
      logic        lst, seen, dn_after;
      logic [15:0] b;
      vec_t        v;
      string       etag;

      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 busy after reset", busy, 0);
      chk("R12 done after reset", done, 0);
      chk("R12 mem_req after reset", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         v = vec_t'(VEC[i]);
         b = 16'h0100 + 16'(i * 8);
         load_cb(b, v.ctl, v.cnt, v.src, v.dst);
         arm_ch_task(i % NUM_CH, v.asrc, v.adst);
         kick(i % NUM_CH, b);
         wait_done(err, lst, seen, dn_after);
         case (v.eerr)
            2'd1:    etag = "R6";
            2'd2:    etag = "R7";
            2'd3:    etag = "R8";
            default: etag = "R1";
         endcase
         chk($sformatf("R9 done seen vec %0d", i), seen, 1);
         chk($sformatf("R9 done one cycle vec %0d", i), dn_after, 0);
         chk($sformatf("%s error code vec %0d", etag, i), err, v.eerr);
         chk($sformatf("R3 last flag vec %0d", i), lst, v.elast);
         chk($sformatf("R3 count written vec %0d", i), mem[b[11:0]], v.ecnt);
         chk($sformatf("R4/R5 source written vec %0d", i), rd16(b + 16'd2), v.esrc);
         chk($sformatf("R4/R5 dest written vec %0d", i), rd16(b + 16'd4), v.edst);
         if (v.eerr == 2'd0) begin
            chk($sformatf("R1 byte 0 moved vec %0d", i), mem[v.dst[11:0]], pat(v.src));
            if (v.ctl[4])
               chk($sformatf("R1 next byte untouched vec %0d", i), mem[v.dst[11:0] + 12'd1], 8'hEE);
            else
               chk($sformatf("R2 byte 1 moved vec %0d", i), mem[v.dst[11:0] + 12'd1], pat(v.src + 16'd1));
         end else begin
            chk($sformatf("%s dest untouched vec %0d", etag, i), rd16(v.dst), 16'hEEEE);
            chk($sformatf("%s control unchanged vec %0d", etag, i), mem[b[11:0] + 12'd1], v.ctl);
         end
      end

      // R10: start while busy is ignored
      load_cb(16'h0180, 8'hB0, 8'd2, 16'h02C0, 16'h04A0);
      load_cb(16'h0188, 8'hB0, 8'h55, 16'h02C8, 16'h04A8);
      arm_ch_task(0, 16'h02C0, 16'h04A0);
      kick(0, 16'h0180);
      repeat (3) @(negedge clk);
      chk("R10 busy during service", busy, 1);
      start = 1'b1; start_ch = 2'd1; cb_base = 16'h0188;
      @(negedge clk);
      start = 1'b0;
      wait_done(err, lst, seen, dn_after);
      chk("R10 first service count", mem[12'h180], 8'd1);
      repeat (40) @(negedge clk);
      chk("R10 second record untouched", mem[12'h188], 8'h55);
      chk("R10 second dest untouched", rd16(16'h04A8), 16'hEEEE);
      chk("R10 no extra service", busy, 0);

      // R11: shadows are per channel
      arm_ch_task(0, 16'h0300, 16'h0500);
      arm_ch_task(1, 16'h0310, 16'h0510);
      load_cb(16'h01A0, 8'hB0, 8'd2, 16'h02D0, 16'h04B0);
      kick(1, 16'h01A0);
      wait_done(err, lst, seen, dn_after);
      chk("R11 channel 1 source shadow", rd16(16'h01A2), 16'h0310);
      chk("R11 channel 1 dest shadow", rd16(16'h01A4), 16'h0510);
      load_cb(16'h01A8, 8'hB0, 8'd2, 16'h02D0, 16'h04B0);
      kick(0, 16'h01A8);
      wait_done(err, lst, seen, dn_after);
      chk("R11 channel 0 source shadow", rd16(16'h01AA), 16'h0300);
      chk("R11 channel 0 dest shadow", rd16(16'h01AC), 16'h0500);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule